// File: doc/BRIEF.md
# Flash Write-Cycle Command Decoder

This block sits on the write side of a byte-wide 256K x 8 flash memory model. It watches every bus write (strobe, 18-bit address, data byte) and looks for the multi-cycle unlock sequences that start an embedded operation. The three operations are byte program, sector erase and chip erase. When a sequence completes, the block sends a one-cycle request to the embedded operation engine. It also latches the target address and data, or the sector, and holds them for the engine.

Out of reset the decoder is in read-array mode, so reads need no command first. Any write that breaks a sequence sends the decoder back to idle. While the engine is busy, or while a request it issued is still outstanding, every write is discarded and the decoder state does not change. When the engine reports done, the decoder returns to read-array mode and clears the latched values. The active-low asynchronous reset aborts whatever is in progress.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `read_mode_o` is 1, both request outputs are 0, and `op_addr_o`, `op_data_o`, `op_sector_o` and `op_chip_o` are 0.
- R2: The writes (addr[10:0]=0x555, 0xAA), (addr[10:0]=0x2AA, 0x55), (addr[10:0]=0x555, 0xA0) and then (A, D) make `prog_req_o` high for exactly one cycle, in the cycle after the fourth write. In that cycle `op_addr_o`=A and `op_data_o`=D. Unlock addresses compare only addr[10:0].
- R3: The same two unlock writes, then (0x555, 0x80), then the two unlock writes again, then any address with data 0x30, make `erase_req_o` pulse for one cycle after the sixth write. With it come `op_chip_o`=0 and `op_sector_o`=addr[17:15] of that sixth write.
- R4: The six-write erase prefix ending in (addr[10:0]=0x555, 0x10) pulses `erase_req_o` with `op_chip_o`=1.
- R5: A write whose address or data does not match the current step returns the decoder to idle. A partial sequence continued after a mismatch produces no request.
- R6: A write while `busy_i` is 1 is ignored: a sequence in progress carries on afterwards, and a full sequence written while busy produces no request.
- R7: From a request until `done_i`, `read_mode_o` is 0. Writes produce no request, and the latched outputs stay stable.
- R8: `done_i` while an operation is outstanding returns `read_mode_o` to 1 one cycle later and clears the latched outputs to 0.
- R9: Asserting `rst_ni` while an operation is outstanding immediately gives `read_mode_o`=1 and cleared latched outputs.
- R10: `prog_req_o` and `erase_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| wr_i | input | 1 | Bus write strobe, one write per cycle high |
| addr_i | input | 18 | Bus write address |
| data_i | input | 8 | Bus write data |
| busy_i | input | 1 | Embedded operation engine busy |
| done_i | input | 1 | Engine finished the outstanding operation |
| read_mode_o | output | 1 | Decoder in read-array mode |
| prog_req_o | output | 1 | One-cycle byte program request |
| erase_req_o | output | 1 | One-cycle erase request |
| op_chip_o | output | 1 | Erase request covers the whole chip |
| op_addr_o | output | 18 | Latched target address |
| op_data_o | output | 8 | Latched program data |
| op_sector_o | output | 3 | Latched sector index |

## Verification
Each operation is driven with its exact sequence and with distinct targets, so a swapped address, data or sector field shows up in the latched outputs. Sequences are then corrupted in a few ways: a wrong unlock address, a wrong set-up code, and a restart after a mismatch. These show whether the decoder really falls back to idle or just skips a step. Writes while busy, both mid-sequence and over a full sequence, separate "ignored" from "reset to idle". Writes during an outstanding operation, then done and an asynchronous reset, exercise holding and releasing the latched values.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PSET, ST_ESET1, ST_ESET2, ST_ESET3, ST_WAIT
  } dec_state_e;

  typedef struct packed {
    logic unl_a;
    logic unl_b;
    logic set_prog;
    logic set_erase;
    logic fin_sect;
    logic fin_chip;
  } step_hit_t;
endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 11,
  parameter logic [KEY_W-1:0]  KEY_A = 11'h555,
  parameter logic [KEY_W-1:0]  KEY_B = 11'h2AA,
  parameter logic [DATA_W-1:0] C_UNL_A = 8'hAA,
  parameter logic [DATA_W-1:0] C_UNL_B = 8'h55,
  parameter logic [DATA_W-1:0] C_PROG  = 8'hA0,
  parameter logic [DATA_W-1:0] C_ERASE = 8'h80,
  parameter logic [DATA_W-1:0] C_SECT  = 8'h30,
  parameter logic [DATA_W-1:0] C_CHIP  = 8'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output step_hit_t         hit_o
);
  logic at_a, at_b;

  assign at_a = (addr_i[KEY_W-1:0] == KEY_A);
  assign at_b = (addr_i[KEY_W-1:0] == KEY_B);

  always_comb begin
    hit_o.unl_a     = at_a && (data_i == C_UNL_A);
    hit_o.unl_b     = at_b && (data_i == C_UNL_B);
    hit_o.set_prog  = at_a && (data_i == C_PROG);
    hit_o.set_erase = at_a && (data_i == C_ERASE);
    hit_o.fin_sect  = (data_i == C_SECT);
    hit_o.fin_chip  = at_a && (data_i == C_CHIP);
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       busy_i,
  input  logic       done_i,
  input  step_hit_t  hit_i,
  output dec_state_e state_o,
  output logic       fire_prog_o,
  output logic       fire_sect_o,
  output logic       fire_chip_o
);
  dec_state_e state_q, state_d;
  logic       accept;

  // writes count only outside busy and outstanding operation
  assign accept = wr_i && !busy_i && (state_q != ST_WAIT);

  always_comb begin
    state_d     = state_q;
    fire_prog_o = 1'b0;
    fire_sect_o = 1'b0;
    fire_chip_o = 1'b0;
    if (state_q == ST_WAIT) begin
      if (done_i) state_d = ST_IDLE;
    end else if (accept) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE:  if (hit_i.unl_a) state_d = ST_UNL1;
        ST_UNL1:  if (hit_i.unl_b) state_d = ST_UNL2;
        ST_UNL2: begin
          if (hit_i.set_prog)       state_d = ST_PSET;
          else if (hit_i.set_erase) state_d = ST_ESET1;
        end
        ST_PSET: begin
          state_d     = ST_WAIT;
          fire_prog_o = 1'b1;
        end
        ST_ESET1: if (hit_i.unl_a) state_d = ST_ESET2;
        ST_ESET2: if (hit_i.unl_b) state_d = ST_ESET3;
        ST_ESET3: begin
          if (hit_i.fin_chip) begin
            state_d     = ST_WAIT;
            fire_chip_o = 1'b1;
          end else if (hit_i.fin_sect) begin
            state_d     = ST_WAIT;
            fire_sect_o = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r6_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && state_q != ST_WAIT) |=> $stable(state_q));

  a_r5_mismatch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNL1 && wr_i && !busy_i && !hit_i.unl_b) |=> state_q == ST_IDLE);
endmodule

// File: rtl/flash_cmd_hold.sv
module flash_cmd_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
    else if (clr_i)  q_o <= '0;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              read_mode_o,
  output logic              prog_req_o,
  output logic              erase_req_o,
  output logic              op_chip_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [SECT_W-1:0] op_sector_o
);
  localparam int HOLD_W = ADDR_W + DATA_W + 1;

  step_hit_t   hit;
  dec_state_e  state;
  logic        fire_prog, fire_sect, fire_chip, fire_any;
  logic        release_op;
  logic [HOLD_W-1:0] hold_q;

  flash_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr_i (addr_i),
    .data_i (data_i),
    .hit_o  (hit)
  );

  flash_cmd_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .busy_i      (busy_i),
    .done_i      (done_i),
    .hit_i       (hit),
    .state_o     (state),
    .fire_prog_o (fire_prog),
    .fire_sect_o (fire_sect),
    .fire_chip_o (fire_chip)
  );

  assign fire_any   = fire_prog | fire_sect | fire_chip;
  assign release_op = (state == ST_WAIT) && done_i;

  flash_cmd_hold #(.W(HOLD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fire_any),
    .clr_i  (release_op),
    .d_i    ({fire_chip, addr_i, data_i}),
    .q_o    (hold_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_req_o  <= 1'b0;
      erase_req_o <= 1'b0;
    end else begin
      prog_req_o  <= fire_prog;
      erase_req_o <= fire_sect | fire_chip;
    end
  end

  assign read_mode_o = (state != ST_WAIT);
  assign op_chip_o   = hold_q[HOLD_W-1];
  assign op_addr_o   = hold_q[ADDR_W+DATA_W-1:DATA_W];
  assign op_data_o   = hold_q[DATA_W-1:0];
  assign op_sector_o = op_addr_o[ADDR_W-1 -: SECT_W];

  a_r10_req_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, erase_req_o}));

  a_r2_prog_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && !done_i) |=> ($stable(op_addr_o) && $stable(op_data_o) && !read_mode_o));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && done_i) |=> (read_mode_o && op_addr_o == '0 && op_data_o == '0));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy = 1'b0;
  logic        done = 1'b0;
  logic        read_mode, prog_req, erase_req, chip;
  logic [17:0] op_addr;
  logic [7:0]  op_data;
  logic [2:0]  sector;

  int checks = 0;
  int errors = 0;
  int prog_cnt = 0;
  int erase_cnt = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .busy_i(busy), .done_i(done), .read_mode_o(read_mode), .prog_req_o(prog_req),
    .erase_req_o(erase_req), .op_chip_o(chip), .op_addr_o(op_addr),
    .op_data_o(op_data), .op_sector_o(sector)
  );

  always @(negedge clk) begin
    if (prog_req)  prog_cnt++;
    if (erase_req) erase_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [17:0] a, input logic [7:0] d);
    addr = a; data = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic seq_prog(input logic [17:0] a, input logic [7:0] d);
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h002AA, 8'h55);
    bus_wr(18'h00555, 8'hA0);
    bus_wr(a, d);
  endtask

  task automatic seq_erase_prefix();
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h002AA, 8'h55);
    bus_wr(18'h00555, 8'h80);
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h002AA, 8'h55);
  endtask

  task automatic finish_op();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    chk(read_mode == 1'b1, "R1 read_mode", read_mode, 1);
    chk(!prog_req && !erase_req, "R1 requests", {prog_req, erase_req}, 0);
    chk(op_addr == 0 && op_data == 0 && sector == 0 && !chip, "R1 latches", op_addr, 0);
  endtask

  task automatic t_program();
    int p0;
    seq_prog(18'h31A2B, 8'h5C);
    chk(prog_req == 1'b1, "R2 prog pulse", prog_req, 1);
    chk(erase_req == 1'b0, "R10 no erase with prog", erase_req, 0);
    chk(op_addr == 18'h31A2B, "R2 op_addr", op_addr, 18'h31A2B);
    chk(op_data == 8'h5C, "R2 op_data", op_data, 8'h5C);
    @(negedge clk);
    chk(prog_req == 1'b0, "R2 single cycle", prog_req, 0);
    chk(read_mode == 1'b0, "R7 not read mode", read_mode, 0);
    p0 = prog_cnt;
    seq_prog(18'h00077, 8'h11);
    @(negedge clk);
    chk(prog_cnt == p0, "R7 no request while outstanding", prog_cnt, p0);
    chk(op_addr == 18'h31A2B && op_data == 8'h5C, "R7 latch stable", op_addr, 18'h31A2B);
    finish_op();
    chk(read_mode == 1'b1, "R8 read mode after done", read_mode, 1);
    chk(op_addr == 0 && op_data == 0, "R8 latch cleared", op_addr, 0);
  endtask

  task automatic t_sector();
    seq_erase_prefix();
    bus_wr(18'h2C123, 8'h30);
    chk(erase_req == 1'b1, "R3 erase pulse", erase_req, 1);
    chk(chip == 1'b0, "R3 sector not chip", chip, 0);
    chk(sector == 3'd5, "R3 sector index", sector, 5);
    chk(prog_req == 1'b0, "R10 no prog with erase", prog_req, 0);
    @(negedge clk);
    chk(erase_req == 1'b0, "R3 single cycle", erase_req, 0);
    finish_op();
  endtask

  task automatic t_chip();
    seq_erase_prefix();
    bus_wr(18'h00555, 8'h10);
    chk(erase_req == 1'b1, "R4 chip erase pulse", erase_req, 1);
    chk(chip == 1'b1, "R4 chip flag", chip, 1);
    @(negedge clk);
    finish_op();
    chk(chip == 1'b0 && read_mode, "R8 chip flag cleared", chip, 0);
  endtask

  task automatic t_mismatch();
    int p0, e0;
    p0 = prog_cnt; e0 = erase_cnt;
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h002AA, 8'h55);
    bus_wr(18'h00555, 8'h90);
    bus_wr(18'h002AA, 8'h55);
    bus_wr(18'h00555, 8'hA0);
    bus_wr(18'h00100, 8'h22);
    @(negedge clk);
    chk(prog_cnt == p0 && erase_cnt == e0, "R5 bad setup code", prog_cnt, p0);
    bus_wr(18'h00556, 8'hAA);
    bus_wr(18'h002AA, 8'h55);
    bus_wr(18'h00555, 8'hA0);
    bus_wr(18'h00100, 8'h22);
    @(negedge clk);
    chk(prog_cnt == p0 && read_mode, "R5 bad unlock address", prog_cnt, p0);
    seq_erase_prefix();
    bus_wr(18'h00555, 8'h31);
    @(negedge clk);
    chk(erase_cnt == e0, "R5 bad final code", erase_cnt, e0);
    seq_prog(18'h10001, 8'h3C);
    chk(prog_req && op_addr == 18'h10001, "R5 recovers after mismatch", op_addr, 18'h10001);
    @(negedge clk);
    finish_op();
  endtask

  task automatic t_busy();
    int p0;
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h002AA, 8'h55);
    busy = 1'b1;
    bus_wr(18'h01234, 8'h00);
    busy = 1'b0;
    bus_wr(18'h00555, 8'hA0);
    bus_wr(18'h20FF0, 8'hE7);
    chk(prog_req && op_data == 8'hE7, "R6 sequence survives busy write", op_data, 8'hE7);
    @(negedge clk);
    finish_op();
    p0 = prog_cnt;
    busy = 1'b1;
    seq_prog(18'h00042, 8'h42);
    @(negedge clk);
    busy = 1'b0;
    chk(prog_cnt == p0 && op_addr == 0, "R6 full sequence while busy", prog_cnt, p0);
  endtask

  task automatic t_abort();
    seq_prog(18'h3FFFF, 8'h81);
    @(negedge clk);
    chk(read_mode == 1'b0, "R9 outstanding before reset", read_mode, 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk(read_mode == 1'b1, "R9 read mode on reset", read_mode, 1);
    chk(op_addr == 0 && op_data == 0, "R9 latch cleared on reset", op_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    seq_prog(18'h00F00, 8'h0F);
    chk(prog_req == 1'b1, "R9 usable after reset", prog_req, 1);
    @(negedge clk);
    finish_op();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_program();
    t_sector();
    t_chip();
    t_mismatch();
    t_busy();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule